// File: doc/BRIEF.md
# Phase-Domain Frequency Error Detector

This block turns one sample of oscillator phase per reference clock into a signed frequency error for the loop filter of a fractional-N digital PLL. It needs no delta-sigma modulator. Each reference edge brings two things. One is the value of a free-running counter of oscillator cycles, captured at that edge. The other is a set of time-to-digital converter samples, in which the five oscillator phases are sampled at eight successively delayed copies of the reference edge. The block decodes the samples to one of 40 sub-steps of an oscillator period and scales the result to a binary fraction. It joins the fraction to the cycle count to form a fixed-point phase word.

Subtracting the previous phase word gives the oscillator frequency over one reference period, in oscillator cycles per reference cycle. The subtraction is done modulo the word width, so counter roll-over is harmless. The measured frequency is then subtracted from a fixed-point frequency command word. The error and the measured frequency are both registered, together with a valid flag. The clock of the block is the reference clock: every rising edge is one phase sample.

Top module: `phase_freq_err_det`

## Requirements
- R1: The integer field of the phase word (its upper CNT_W bits) equals the counter value `cnt_i` presented at the sampling edge.
- R2: `tdc_i[k*5 +: 5]` holds the five phase bits seen at delayed edge k (k = 0..7, edge 0 undelayed, each later edge one sub-step later). Each 5-bit word is a thermometer code, and its sector is the number of ones minus one, with zero ones read as sector 0. The sub-step code is 8*sector(edge 0) plus the number of edges 1..7 whose sector differs from that of edge 0, so it runs from 0 to 39.
- R3: The fractional field (the low 6 bits of the phase word) is floor((code*64 + 20)/40). Code 0 gives 0, code 20 gives 32 and code 39 gives 62.
- R4: `freq_o` is (phase now − previous phase) modulo 2^(CNT_W+6), so a counter that rolls over from its top value still yields a small positive frequency.
- R5: `err_o` is the signed difference `fcw_i − freq`, CNT_W+7 bits wide. Both operands are unsigned with 6 fraction bits. The error and the frequency appear on the outputs after the rising edge that samples the phase.
- R6: The first sample after reset raises no `vld_o`. The outputs stay at zero until the second sample, which raises `vld_o`.
- R7: Once `vld_o` is high, it stays high on every later cycle until reset.
- R8: A synchronous reset clears `err_o`, `freq_o`, `vld_o` and the stored previous phase, so a phase taken before the reset never enters a later difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; each rising edge is one phase sample |
| rst | input | 1 | Synchronous reset, active high |
| cnt_i | input | CNT_W (10) | Oscillator cycle count captured at this reference edge |
| tdc_i | input | 40 | Phase samples: five phase bits per delayed edge, eight edges |
| fcw_i | input | CNT_W+6 (16) | Frequency command word, unsigned, 6 fraction bits |
| err_o | output | CNT_W+7 (17) | Signed frequency error, command minus measured |
| freq_o | output | CNT_W+6 (16) | Measured frequency over the last reference period |
| vld_o | output | 1 | High when err_o and freq_o hold a real difference |

## Verification
The bench goes after counter roll-over in both directions. A design that took a plain difference without wrap would report a frequency near the full range on the sample after the counter passes its top value. It also drives the fraction across its own wrap, from code 39 to a small code with the count advanced by one. A decoder that counted the matching delayed edges instead of the differing ones would give a mirrored sub-step and a wrong fraction. A reset in the middle of a run must be followed by a quiet first sample. A design that kept the stale previous phase would emit a large false error at once. Negative errors, where the oscillator runs faster than commanded, check that the sign extension of the error is correct.

// File: rtl/pfed_pkg.sv
package pfed_pkg;
    // Default geometry of the phase detector
    localparam int unsigned PFED_CNT_W  = 10; // rotational counter width
    localparam int unsigned PFED_NPH    = 5;  // oscillator phases
    localparam int unsigned PFED_NDLY   = 8;  // delayed reference edges
    localparam int unsigned PFED_FRAC_W = 6;  // binary fraction bits
endpackage

// File: rtl/pfed_tdc_decode.sv
module pfed_tdc_decode #(
    parameter int unsigned NPH    = pfed_pkg::PFED_NPH,
    parameter int unsigned NDLY   = pfed_pkg::PFED_NDLY,
    parameter int unsigned CODE_W = $clog2(NPH * NDLY)
) (
    input  logic [NPH*NDLY-1:0] tdc_i,
    output logic [CODE_W-1:0]   code_o
);
    localparam int unsigned SEC_W = (NPH > 1) ? $clog2(NPH) : 1;
    localparam int unsigned FIN_W = $clog2(NDLY) + 1;

    // Sector of one thermometer word: ones minus one, empty word reads as 0
    function automatic logic [SEC_W-1:0] sector_of(input logic [NPH-1:0] w);
        int unsigned ones;
        ones = 0;
        for (int p = 0; p < int'(NPH); p++) begin
            ones += int'(w[p]);
        end
        return (ones == 0) ? '0 : SEC_W'(ones - 1);
    endfunction

    logic [NDLY*SEC_W-1:0] sec_flat;

    for (genvar k = 0; k < NDLY; k++) begin : g_edge
        assign sec_flat[k*SEC_W +: SEC_W] = sector_of(tdc_i[k*NPH +: NPH]);
    end

    logic [FIN_W-1:0] fine;
    always_comb begin
        fine = '0;
        for (int k = 1; k < int'(NDLY); k++) begin
            if (sec_flat[k*SEC_W +: SEC_W] != sec_flat[SEC_W-1:0]) begin
                fine = fine + FIN_W'(1);
            end
        end
        code_o = CODE_W'(NDLY) * CODE_W'(sec_flat[SEC_W-1:0]) + CODE_W'(fine);
    end
endmodule

// File: rtl/pfed_phase_form.sv
module pfed_phase_form #(
    parameter int unsigned CNT_W  = pfed_pkg::PFED_CNT_W,
    parameter int unsigned FRAC_W = pfed_pkg::PFED_FRAC_W,
    parameter int unsigned NSTEP  = pfed_pkg::PFED_NPH * pfed_pkg::PFED_NDLY,
    parameter int unsigned CODE_W = $clog2(NSTEP)
) (
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic [CODE_W-1:0]       code_i,
    output logic [CNT_W+FRAC_W-1:0] phase_o
);
    localparam int unsigned PRD_W = CODE_W + FRAC_W + 2;

    logic [PRD_W-1:0]  num;
    logic [PRD_W-1:0]  quo;
    logic [FRAC_W-1:0] frac;

    // Round-half-up scaling of a 0..NSTEP-1 code onto 2**FRAC_W
    always_comb begin
        num     = (PRD_W'(code_i) << FRAC_W) + PRD_W'(NSTEP / 2);
        quo     = num / PRD_W'(NSTEP);
        frac    = quo[FRAC_W-1:0];
        phase_o = {cnt_i, frac};
    end
endmodule

// File: rtl/pfed_freq_diff.sv
module pfed_freq_diff #(
    parameter int unsigned PH_W = pfed_pkg::PFED_CNT_W + pfed_pkg::PFED_FRAC_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PH_W-1:0]        phase_i,
    input  logic [PH_W-1:0]        fcw_i,
    output logic [PH_W-1:0]        freq_o,
    output logic signed [PH_W:0]   err_o,
    output logic                   vld_o
);
    localparam int unsigned ERR_W = PH_W + 1;

    typedef struct packed {
        logic                    have;
        logic                    vld;
        logic [PH_W-1:0]         prev;
        logic [PH_W-1:0]         freq;
        logic signed [ERR_W-1:0] err;
    } diff_st_t;

    diff_st_t st_d, st_q;
    logic [PH_W-1:0] step;

    always_comb begin
        st_d = st_q;
        step = phase_i - st_q.prev; // modulo 2**PH_W by width
        if (st_q.have) begin
            st_d.freq = step;
            st_d.err  = $signed({1'b0, fcw_i}) - $signed({1'b0, step});
            st_d.vld  = 1'b1;
        end
        st_d.prev = phase_i;
        st_d.have = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign freq_o = st_q.freq;
    assign err_o  = st_q.err;
    assign vld_o  = st_q.vld;

    // R4: measured step equals the phase advance between the last two samples
    a_r4_step_wraps: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (freq_o == PH_W'($past(phase_i) - $past(phase_i, 2))));

    // R7: valid is sticky until reset
    a_r7_valid_sticks: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> vld_o);
endmodule

// File: rtl/phase_freq_err_det.sv
module phase_freq_err_det #(
    parameter int unsigned CNT_W  = pfed_pkg::PFED_CNT_W,
    parameter int unsigned NPH    = pfed_pkg::PFED_NPH,
    parameter int unsigned NDLY   = pfed_pkg::PFED_NDLY,
    parameter int unsigned FRAC_W = pfed_pkg::PFED_FRAC_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CNT_W-1:0]              cnt_i,
    input  logic [NPH*NDLY-1:0]           tdc_i,
    input  logic [CNT_W+FRAC_W-1:0]       fcw_i,
    output logic signed [CNT_W+FRAC_W:0]  err_o,
    output logic [CNT_W+FRAC_W-1:0]       freq_o,
    output logic                          vld_o
);
    localparam int unsigned NSTEP  = NPH * NDLY;
    localparam int unsigned CODE_W = $clog2(NSTEP);
    localparam int unsigned PH_W   = CNT_W + FRAC_W;

    logic [CODE_W-1:0] code_w;
    logic [PH_W-1:0]   phase_w;

    pfed_tdc_decode #(.NPH(NPH), .NDLY(NDLY), .CODE_W(CODE_W)) u_dec (
        .tdc_i  (tdc_i),
        .code_o (code_w)
    );

    pfed_phase_form #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .NSTEP(NSTEP), .CODE_W(CODE_W)) u_form (
        .cnt_i   (cnt_i),
        .code_i  (code_w),
        .phase_o (phase_w)
    );

    pfed_freq_diff #(.PH_W(PH_W)) u_diff (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase_w),
        .fcw_i   (fcw_i),
        .freq_o  (freq_o),
        .err_o   (err_o),
        .vld_o   (vld_o)
    );

    // R2: decoded sub-step never leaves one oscillator period
    a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
        code_w < CODE_W'(NSTEP));

    // R1: integer field of the phase is the captured count
    a_r1_int_field: assert property (@(posedge clk) disable iff (rst)
        phase_w[PH_W-1:FRAC_W] == cnt_i);

    // R6: the sample taken right after reset gives no valid error
    a_r6_first_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |=> !vld_o);
endmodule

// File: tb/sim_phase_freq_err_det.sv
module sim_phase_freq_err_det;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [9:0]        cnt_i = '0;
    logic [39:0]       tdc_i = '0;
    logic [15:0]       fcw_i = '0;
    logic signed [16:0] err_o;
    logic [15:0]       freq_o;
    logic              vld_o;

    int n_chk  = 0;
    int n_fail = 0;

    bit          m_have = 0;
    logic [15:0] m_prev = '0;

    always #2 clk = ~clk; // 250 MHz

    phase_freq_err_det u0 (
        .clk(clk), .rst(rst), .cnt_i(cnt_i), .tdc_i(tdc_i),
        .fcw_i(fcw_i), .err_o(err_o), .freq_o(freq_o), .vld_o(vld_o)
    );

    // {count[9:0], code[5:0], fcw[15:0]}
    localparam logic [31:0] VEC [12] = '{
        {10'd5,    6'd0,  16'd640},
        {10'd15,   6'd13, 16'd640},
        {10'd26,   6'd39, 16'd700},
        {10'd36,   6'd0,  16'd700},
        {10'd46,   6'd20, 16'd640},
        {10'd1020, 6'd20, 16'd40000},
        {10'd3,    6'd7,  16'd450},
        {10'd14,   6'd8,  16'd704},
        {10'd14,   6'd30, 16'd10},
        {10'd20,   6'd1,  16'd500},
        {10'd1023, 6'd39, 16'd0},
        {10'd0,    6'd2,  16'd64}
    };

    function automatic logic [39:0] enc(input int code);
        logic [39:0] t;
        t = '0;
        for (int k = 0; k < 8; k++) begin
            int pos, sec;
            pos = (code + k) % 40;
            sec = pos / 8;
            t[k*5 +: 5] = 5'((1 << (sec + 1)) - 1);
        end
        return t;
    endfunction

    function automatic logic [15:0] ph_of(input int cnt, input int code);
        return 16'((cnt << 6) + (code * 64 + 20) / 40);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at negedge, sample 1 ns after the rising edge
    task automatic sample(input int cnt, input int code, input int fcw, input string req);
        logic [15:0] ph, f;
        logic signed [16:0] e;
        bit exp_v;
        cnt_i = 10'(cnt); tdc_i = enc(code); fcw_i = 16'(fcw);
        @(posedge clk); #1;
        ph = ph_of(cnt, code);
        exp_v = m_have;
        f = ph - m_prev;
        e = $signed({1'b0, 16'(fcw)}) - $signed({1'b0, f});
        chk(vld_o == exp_v, {req, " valid"}, vld_o, exp_v);
        if (exp_v) begin
            chk(freq_o == f, {req, " freq"}, freq_o, f);
            chk(err_o == e, {req, " err"}, err_o, e);
        end
        m_have = 1; m_prev = ph;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_have = 0; m_prev = '0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(vld_o == 0, "R8 reset vld", vld_o, 0);
        chk(err_o == 0, "R8 reset err", err_o, 0);
        chk(freq_o == 0, "R8 reset freq", freq_o, 0);
        rst = 1'b0;
        m_have = 0;

        // Table walk: R1 R2 R3 R4 R5, first entry covers R6
        for (int i = 0; i < 12; i++) begin
            sample(int'(VEC[i][31:22]), int'(VEC[i][21:16]), int'(VEC[i][15:0]), "R5 table");
        end

        // R3: exact fraction points, step of one code from code 0
        do_reset();
        sample(100, 0, 0, "R6 first");
        sample(100, 20, 32, "R3 code20");   // frac 32, error 0
        chk(err_o == 0, "R3 half period", err_o, 0);
        sample(100, 39, 30, "R3 code39");   // frac 62, step 30
        chk(freq_o == 16'd30, "R3 top code", freq_o, 30);

        // R4: counter roll-over gives small positive step
        sample(1023, 0, 0, "R4 pre");
        sample(1, 0, 128, "R4 wrap");
        chk(freq_o == 16'd128, "R4 wrap freq", freq_o, 128);

        // R5: oscillator faster than command gives negative error
        sample(50, 0, 100, "R5 negative");
        chk(err_o < 0, "R5 sign", err_o, -1);

        // R2: fraction wrap from code 39 to code 1 with count+1
        sample(60, 39, 0, "R2 pre");
        sample(61, 1, 0, "R2 wrap");
        chk(freq_o == 16'd4, "R2 wrap freq", freq_o, 4);

        // R7: valid stays high over a run
        for (int i = 0; i < 20; i++) begin
            sample(61 + 3 * i, i % 40, 192, "R7 run");
            chk(vld_o == 1, "R7 sticky", vld_o, 1);
        end

        // R8 + R6: reset mid-run drops stale phase
        do_reset();
        chk(vld_o == 0, "R8 mid reset vld", vld_o, 0);
        sample(900, 10, 0, "R6 after reset");
        sample(902, 10, 128, "R8 fresh diff");
        chk(err_o == 0, "R8 no stale phase", err_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule